// File: doc/BRIEF.md
# Wide-word to byte register bus bridge

This block is a Wishbone classic slave that fronts a narrow control/status register bus. The master issues one word-wide access. The bridge breaks it into single-lane register accesses, one lane at a time. The lowest lane goes first, and each lane sits at the next register address after the one before it. A word at bus address A covers register addresses A*LANES through A*LANES+LANES-1. Lanes whose byte selects are all clear cause no register activity and take no cycle. Read lanes are gathered back into the read word. Ack is pulsed once every selected lane has finished.

The register width (`CSR_DW`, default 8) must be 8, 16, 32 or 64. The word width (`WB_DW`, default 32) must be a whole multiple of it. Any other pairing stops elaboration with a fatal message. When the two widths match, each bus address maps to one register address. A register lane counts as selected when any byte select inside it is set.

Top module: `wbcb_bridge`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wb_ack`, `csr_re` and `csr_we` are low.
- R2: Lane l of the word at bus address A is accessed at register address A*LANES + l. With the defaults, LANES is 4 and lane l holds bits [8l+7:8l].
- R3: Selected lanes are accessed strictly in rising lane order, one access per clock with no idle cycle between them.
- R4: A register write for lane l carries `wb_dat_w` bits [8l+7:8l]. With default widths, a full-select write of 0x44332211 gives 0x11, 0x22, 0x33, 0x44 at offsets 0, 1, 2, 3.
- R5: A lane whose byte selects are all zero gets neither a read strobe nor a write strobe. With `wb_sel` = 0110, only lanes 1 and 2 are accessed.
- R6: On a read, each selected lane of `wb_dat_r` holds the `csr_rdata` value given in the cycle after that lane's `csr_re`. Unselected lanes read as zero, so a middle-lane read of 0x..3322.. returns 0x00332200.
- R7: `wb_ack` is a one-cycle pulse given once per request, after the last selected lane has finished. A request with no byte selected is still acknowledged and makes no register access.
- R8: `csr_re` and `csr_we` are never high together, and neither is high outside a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Request strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | ADR_W | Word address |
| wb_dat_w | input | WB_DW | Write word |
| wb_sel | input | WB_DW/8 | Byte selects |
| wb_dat_r | output | WB_DW | Read word, valid with ack |
| wb_ack | output | 1 | One-cycle acknowledge |
| csr_addr | output | ADR_W+log2(LANES) | Register address |
| csr_re | output | 1 | Register read strobe |
| csr_we | output | 1 | Register write strobe |
| csr_wdata | output | CSR_DW | Register write data |
| csr_rdata | input | CSR_DW | Register read data, one cycle after csr_re |

## Verification
The base-address assertion assumes the master keeps `wb_adr`, `wb_we`, `wb_sel` and `wb_dat_w` steady from the strobe until ack. It also assumes the master drops `wb_stb` as soon as it sees ack. The bench drives every request this way, in random and directed requests alike. The register-side model always answers one cycle after `csr_re`. In every other cycle it drives random values on `csr_rdata`, so a capture taken in the wrong cycle corrupts the read word.

// File: rtl/wbcb_pkg.sv
package wbcb_pkg;

  function automatic bit csr_width_ok(int w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64);
  endfunction

  function automatic int idx_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wbcb_lane_pick.sv
module wbcb_lane_pick #(
  parameter int N  = 4,
  parameter int IW = wbcb_pkg::idx_bits(N)
) (
  input  logic [N-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/wbcb_read_gather.sv
module wbcb_read_gather #(
  parameter int LANES  = 4,
  parameter int CSR_DW = 8,
  parameter int LW     = wbcb_pkg::idx_bits(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    cap_en,
  input  logic [LW-1:0]           cap_lane,
  input  logic [CSR_DW-1:0]       cap_data,
  output logic [LANES*CSR_DW-1:0] word
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        word[l*CSR_DW +: CSR_DW] <= '0;
      end else if (cap_en && cap_lane == LW'(l)) begin
        word[l*CSR_DW +: CSR_DW] <= cap_data;
      end
    end
  end
endmodule

// File: rtl/wbcb_bridge.sv
module wbcb_bridge #(
  parameter int WB_DW  = 32,
  parameter int CSR_DW = 8,
  parameter int ADR_W  = 8,
  localparam int LANES  = WB_DW / CSR_DW,
  localparam int LAW    = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int LW     = wbcb_pkg::idx_bits(LANES),
  localparam int SEL_W  = WB_DW / 8,
  localparam int SPL    = CSR_DW / 8,
  localparam int CSR_AW = ADR_W + LAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [ADR_W-1:0]  wb_adr,
  input  logic [WB_DW-1:0]  wb_dat_w,
  input  logic [SEL_W-1:0]  wb_sel,
  output logic [WB_DW-1:0]  wb_dat_r,
  output logic              wb_ack,
  output logic [CSR_AW-1:0] csr_addr,
  output logic              csr_re,
  output logic              csr_we,
  output logic [CSR_DW-1:0] csr_wdata,
  input  logic [CSR_DW-1:0] csr_rdata
);
  if (!wbcb_pkg::csr_width_ok(CSR_DW) || (WB_DW < CSR_DW) ||
      (WB_DW % CSR_DW != 0)) begin : g_bad_cfg
    $fatal(1, "wbcb_bridge: register width must be 8/16/32/64 and divide the word width");
  end

  logic [LANES-1:0] lane_sel;
  for (genvar l = 0; l < LANES; l++) begin : g_sel
    assign lane_sel[l] = |wb_sel[l*SPL +: SPL];
  end

  logic              busy;
  logic [LANES-1:0]  pend;
  logic [LANES-1:0]  sel_q;
  logic              we_q;
  logic [ADR_W-1:0]  adr_q;
  logic [WB_DW-1:0]  wdata_q;
  logic [LW-1:0]     csr_lane;
  logic              cap_v;
  logic [LW-1:0]     cap_lane;
  logic              pick_any;
  logic [LW-1:0]     pick_idx;
  logic              accept;
  logic [WB_DW-1:0]  gathered;

  assign accept = !busy && wb_cyc && wb_stb && !wb_ack;

  wbcb_lane_pick #(.N(LANES), .IW(LW)) i_pick (
    .mask (pend),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  wbcb_read_gather #(.LANES(LANES), .CSR_DW(CSR_DW), .LW(LW)) i_gather (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .cap_en   (cap_v),
    .cap_lane (cap_lane),
    .cap_data (csr_rdata),
    .word     (gathered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pend      <= '0;
      sel_q     <= '0;
      we_q      <= 1'b0;
      adr_q     <= '0;
      wdata_q   <= '0;
      csr_addr  <= '0;
      csr_re    <= 1'b0;
      csr_we    <= 1'b0;
      csr_wdata <= '0;
      csr_lane  <= '0;
      cap_v     <= 1'b0;
      cap_lane  <= '0;
      wb_ack    <= 1'b0;
      wb_dat_r  <= '0;
    end else begin
      csr_re   <= 1'b0;
      csr_we   <= 1'b0;
      wb_ack   <= 1'b0;
      cap_v    <= csr_re;
      cap_lane <= csr_lane;
      if (!busy) begin
        if (accept) begin
          busy    <= 1'b1;
          pend    <= lane_sel;
          sel_q   <= lane_sel;
          we_q    <= wb_we;
          adr_q   <= wb_adr;
          wdata_q <= wb_dat_w;
        end
      end else if (pick_any) begin
        csr_addr       <= (CSR_AW'(adr_q) << LAW) | CSR_AW'(pick_idx);
        csr_we         <= we_q;
        csr_re         <= !we_q;
        csr_wdata      <= wdata_q[pick_idx*CSR_DW +: CSR_DW];
        csr_lane       <= pick_idx;
        pend[pick_idx] <= 1'b0;
      end else if (!csr_re && !csr_we && !cap_v) begin
        busy     <= 1'b0;
        wb_ack   <= 1'b1;
        wb_dat_r <= gathered;
      end
    end
  end

  // R8
  csr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(csr_re && csr_we));

  // R8
  csr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !(csr_re || csr_we));

  // R5
  csr_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_re || csr_we) |-> sel_q[csr_lane]);

  // R2
  csr_base_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_re || csr_we) |-> ((csr_addr >> LAW) == CSR_AW'(wb_adr)));

  // R3
  lane_order_chk: assert property (@(posedge clk) disable iff (rst)
    ((csr_re || csr_we) && $past(csr_re || csr_we)) |-> (csr_lane > $past(csr_lane)));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);
endmodule

// File: tb/test_wbcb_bridge.sv
module test_wbcb_bridge;
  localparam int WB_DW = 32;
  localparam int CSR_DW = 8;
  localparam int ADR_W = 8;
  localparam int LANES = WB_DW / CSR_DW;
  localparam int CSR_AW = ADR_W + 2;
  localparam int NMEM = 1 << CSR_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [ADR_W-1:0] wb_adr = '0;
  logic [WB_DW-1:0] wb_dat_w = '0;
  logic [LANES-1:0] wb_sel = '0;
  logic [WB_DW-1:0] wb_dat_r;
  logic wb_ack;
  logic [CSR_AW-1:0] csr_addr;
  logic csr_re, csr_we;
  logic [CSR_DW-1:0] csr_wdata;
  logic [CSR_DW-1:0] csr_rdata = '0;

  always #2.5 clk = ~clk;

  wbcb_bridge #(.WB_DW(WB_DW), .CSR_DW(CSR_DW), .ADR_W(ADR_W)) i_wbcb_bridge (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .csr_addr(csr_addr), .csr_re(csr_re), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] mem [NMEM];
  logic [7:0] ref_mem [NMEM];
  logic rd_pend = 1'b0;
  logic [CSR_AW-1:0] rd_addr = '0;
  logic in_txn = 1'b0;
  int acc_n = 0;
  logic [CSR_AW-1:0] acc_addr [16];
  logic acc_we [16];
  logic [7:0] acc_dat [16];
  int cycles = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // register-side model and strobe monitor
  always @(negedge clk) begin
    cycles++;
    if (rd_pend) csr_rdata = mem[rd_addr];
    else csr_rdata = 8'($urandom);
    rd_pend = csr_re;
    rd_addr = csr_addr;
    if (csr_we) mem[csr_addr] = csr_wdata;
    if (!rst) begin
      if (csr_re && csr_we) check(1'b0, "R8 both strobes", 1, 0);
      if ((csr_re || csr_we) && !in_txn) check(1'b0, "R8 strobe outside request", 1, 0);
      if ((csr_re || csr_we) && in_txn) begin
        if (acc_n < 16) begin
          acc_addr[acc_n] = csr_addr;
          acc_we[acc_n] = csr_we;
          acc_dat[acc_n] = csr_wdata;
        end
        acc_n++;
      end
    end
  end

  task automatic run(input logic we, input logic [ADR_W-1:0] adr,
                     input logic [WB_DW-1:0] dat, input logic [LANES-1:0] sel);
    int exp_n;
    int k;
    int wait_c;
    logic [WB_DW-1:0] exp_r;
    logic [WB_DW-1:0] got_r;
    exp_n = $countones(sel);
    acc_n = 0;
    in_txn = 1'b1;
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr;
    wb_dat_w = dat; wb_sel = sel;
    wait_c = 0;
    do begin
      @(negedge clk);
      wait_c++;
    end while (!wb_ack && wait_c < 64);
    check(wb_ack, "R7 ack reached", wait_c, 64);
    got_r = wb_dat_r;
    wb_stb = 1'b0; wb_cyc = 1'b0;
    @(negedge clk);
    check(!wb_ack, "R7 ack single cycle", wb_ack, 0);
    in_txn = 1'b0;
    check(acc_n == exp_n, "R5 access count", acc_n, exp_n);
    k = 0;
    for (int l = 0; l < LANES; l++) begin
      if (sel[l] && k < acc_n && k < 16) begin
        check(acc_addr[k] == CSR_AW'(adr) * LANES + CSR_AW'(l), "R2 R3 lane address",
              acc_addr[k], CSR_AW'(adr) * LANES + CSR_AW'(l));
        check(acc_we[k] == we, "R8 strobe kind", acc_we[k], we);
        if (we) check(acc_dat[k] == dat[l*8 +: 8], "R4 lane data", acc_dat[k], dat[l*8 +: 8]);
        k++;
      end
    end
    exp_r = '0;
    for (int l = 0; l < LANES; l++) begin
      if (sel[l]) begin
        if (we) ref_mem[adr * LANES + l] = dat[l*8 +: 8];
        else exp_r[l*8 +: 8] = ref_mem[adr * LANES + l];
      end
    end
    if (!we) check(got_r == exp_r, "R6 read word", got_r, exp_r);
  endtask

  initial begin
    for (int i = 0; i < NMEM; i++) begin
      mem[i] = 8'h00;
      ref_mem[i] = 8'h00;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!wb_ack && !csr_re && !csr_we, "R1 reset outputs", {wb_ack, csr_re, csr_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!wb_ack && !csr_re && !csr_we, "R1 after reset", {wb_ack, csr_re, csr_we}, 0);
    // directed corner cases
    run(1'b1, 8'd0, 32'h44332211, 4'b1111);   // R4 full word, lane order
    run(1'b1, 8'd0, 32'haabbccdd, 4'b0110);   // R5 middle lanes only
    run(1'b0, 8'd0, 32'h0, 4'b1111);          // R6 expect 44bbcc11
    run(1'b0, 8'd0, 32'h0, 4'b0110);          // R6 unselected lanes zero
    run(1'b1, 8'd255, 32'hdeadbeef, 4'b1001); // R2 top address, sparse lanes
    run(1'b0, 8'd255, 32'h0, 4'b1111);
    run(1'b0, 8'd7, 32'h0, 4'b0000);          // R7 empty select
    run(1'b1, 8'd7, 32'h12345678, 4'b0000);   // R7 empty select write
    run(1'b0, 8'd7, 32'h0, 4'b1111);
    for (int t = 0; t < 300; t++) begin
      run(1'($urandom), ADR_W'($urandom % 16), $urandom, LANES'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    check(1'b0, "R7 watchdog", cycles, 150000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule